// File: doc/BRIEF.md
# Synchronized Clock Divider Bank

A bank of integer clock dividers that all run from one source clock. Each divider produces a one-cycle strobe, which serves as a clock enable, once every N source cycles. N is set by a small ratio field in that divider's own register. Software writes new ratios and enable bits into a pending copy of each register. The dividers keep running at their current settings until software writes a GO command.

After GO, the bank raises a busy flag. It then waits for a source cycle on which every running divider sits on its final count. On that cycle every divider loads its pending setting and restarts from zero in the same cycle, so the divided outputs stay phase-aligned with one another. The busy flag then drops. Software polls the flag before it writes new settings and again after it issues GO.

Top module: `sync_div_bank`

## Requirements
- R1: While reset is applied and on the first cycle after it, every strobe output is low and busy is low. Every divider register reads 0, and the status register reads 0.
- R2: A divider register keeps the ratio in bits [4:0] and the enable in bit 15. A read returns these two fields as last written, and every other bit reads 0.
- R3: Writing a divider register changes only its pending copy. The strobes keep their current ratio and enable until the next commit, and a read returns the pending value.
- R4: A write to address 0x138 with bit 0 set, made while idle, sets busy on the next cycle. Bit 0 of the register at 0x13C always reads the busy flag.
- R5: While busy, the commit takes place on the first cycle on which every enabled divider is at its terminal count, and not before. After the commit every divider restarts from count zero and busy is low.
- R6: An enabled divider with ratio r strobes once every r+1 cycles. Its first strobe comes r cycles after the commit, counting the first cycle after the commit as cycle 0.
- R7: A divider whose active enable is 0 produces no strobes.
- R8: A GO write made while busy is ignored. A GO write on the commit cycle does not re-arm busy.
- R9: Dividers 0 to 2 sit at 0x118, 0x11C and 0x120. Dividers 3 to 8 sit at 0x160 to 0x174 in steps of 4. A write to any other address, such as 0x124 or 0x15C, changes no register, and a read of such an address returns 0.
- R10: A write to 0x138 with bit 0 clear has no effect. Busy never rises without a GO write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W (12) | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| div_tick | output | NUM_DIV (9) | One strobe per divider, high for one cycle at each divided period |
| busy | output | 1 | High from GO until the aligned commit |

## Verification
The hardest case to reach is a commit that has to wait. It happens only when several dividers with different periods are running and none is at its terminal count when GO arrives. The stimulus builds up a set of active periods that all divide 96 and reprograms one divider per step, so each commit waits for a real common wrap. The bench checks that on the sample just before busy falls, every enabled strobe is high. A repeated GO issued while the long period-32 divider holds busy covers the ignored command.

// File: rtl/sdb_pkg.sv
package sdb_pkg;

    // Field layout of a divider register
    localparam int RATIO_W = 5;
    localparam int EN_POS  = 15;

    // Address map
    localparam int CMD_ADDR     = 'h138;
    localparam int STAT_ADDR    = 'h13C;
    localparam int BANK_A_BASE  = 'h118;
    localparam int BANK_A_COUNT = 3;
    localparam int BANK_B_BASE  = 'h160;

    typedef struct packed {
        logic               en;
        logic [RATIO_W-1:0] ratio;
    } div_cfg_t;

    // Byte address of divider idx (0-based): two banks, not contiguous
    function automatic logic [11:0] div_addr(input int idx);
        if (idx < BANK_A_COUNT)
            return 12'(BANK_A_BASE + 4 * idx);
        else
            return 12'(BANK_B_BASE + 4 * (idx - BANK_A_COUNT));
    endfunction

    // Register image of a divider setting
    function automatic logic [31:0] cfg_word(input div_cfg_t c);
        logic [31:0] w;
        w                 = '0;
        w[EN_POS]         = c.en;
        w[RATIO_W-1:0]    = c.ratio;
        return w;
    endfunction

    function automatic div_cfg_t word_cfg(input logic [31:0] w);
        div_cfg_t c;
        c.en    = w[EN_POS];
        c.ratio = w[RATIO_W-1:0];
        return c;
    endfunction

endpackage

// File: rtl/sdb_regfile.sv
module sdb_regfile
    import sdb_pkg::*;
#(
    parameter int NUM_DIV = 9,
    parameter int ADDR_W  = 12
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      we,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [31:0]               wdata,
    input  logic                      busy_i,
    output div_cfg_t [NUM_DIV-1:0]    pend_cfg,
    output logic                      go_req,
    output logic [31:0]               rdata
);

    logic [NUM_DIV-1:0] hit;
    logic               cmd_hit;
    logic               stat_hit;

    generate
        for (genvar g = 0; g < NUM_DIV; g++) begin : g_dec
            assign hit[g] = (addr == ADDR_W'(div_addr(g)));
        end
    endgenerate

    assign cmd_hit  = (addr == ADDR_W'(CMD_ADDR));
    assign stat_hit = (addr == ADDR_W'(STAT_ADDR));
    assign go_req   = we && cmd_hit && wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_cfg <= '0;
        end else if (we) begin
            for (int i = 0; i < NUM_DIV; i++) begin
                if (hit[i])
                    pend_cfg[i] <= word_cfg(wdata);
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_DIV; i++) begin
            if (hit[i])
                rdata = cfg_word(pend_cfg[i]);
        end
        if (stat_hit)
            rdata[0] = busy_i;
    end

    logic unused_wbits;
    assign unused_wbits = ^{wdata[31:EN_POS+1], wdata[EN_POS-1:RATIO_W]};

endmodule

// File: rtl/sdb_divider.sv
module sdb_divider
    import sdb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     commit,
    input  div_cfg_t new_cfg,
    output logic     tick,
    output logic     at_end
);

    div_cfg_t           act;
    logic [RATIO_W-1:0] cnt;
    logic               wrap;

    assign wrap   = (cnt == act.ratio);
    assign tick   = act.en && wrap;
    assign at_end = !act.en || wrap;

    always_ff @(posedge clk) begin
        if (rst) begin
            act <= '0;
            cnt <= '0;
        end else if (commit) begin
            act <= new_cfg;
            cnt <= '0;
        end else if (!act.en) begin
            cnt <= '0;
        end else if (wrap) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/sdb_sequencer.sv
module sdb_sequencer (
    input  logic clk,
    input  logic rst,
    input  logic go_req,
    input  logic aligned,
    output logic busy,
    output logic commit
);

    assign commit = busy && aligned;

    always_ff @(posedge clk) begin
        if (rst)
            busy <= 1'b0;
        else if (commit)
            busy <= 1'b0;
        else if (go_req)
            busy <= 1'b1;
    end

endmodule

// File: rtl/sync_div_bank.sv
module sync_div_bank
    import sdb_pkg::*;
#(
    parameter int NUM_DIV = 9,
    parameter int ADDR_W  = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic [NUM_DIV-1:0] div_tick,
    output logic               busy
);

    div_cfg_t [NUM_DIV-1:0] pend_cfg;
    logic                   go_req;
    logic                   commit;
    logic [NUM_DIV-1:0]     at_end;
    logic                   aligned;

    sdb_regfile #(.NUM_DIV(NUM_DIV), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .we       (bus_we),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .busy_i   (busy),
        .pend_cfg (pend_cfg),
        .go_req   (go_req),
        .rdata    (bus_rdata)
    );

    generate
        for (genvar g = 0; g < NUM_DIV; g++) begin : g_div
            sdb_divider u_div (
                .clk     (clk),
                .rst     (rst),
                .commit  (commit),
                .new_cfg (pend_cfg[g]),
                .tick    (div_tick[g]),
                .at_end  (at_end[g])
            );
        end
    endgenerate

    assign aligned = &at_end;

    sdb_sequencer u_seq (
        .clk     (clk),
        .rst     (rst),
        .go_req  (go_req),
        .aligned (aligned),
        .busy    (busy),
        .commit  (commit)
    );

endmodule

// File: rtl/sync_div_bank_chk.sv
module sync_div_bank_chk
    import sdb_pkg::*;
#(
    parameter int NUM_DIV = 9,
    parameter int ADDR_W  = 12
) (
    input logic               clk,
    input logic               rst,
    input logic               bus_we,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [31:0]        bus_wdata,
    input logic [31:0]        bus_rdata,
    input logic [NUM_DIV-1:0] div_tick,
    input logic               busy,
    input logic               aligned
);

    logic go_wr;
    assign go_wr = bus_we && (bus_addr == ADDR_W'(CMD_ADDR)) && bus_wdata[0];

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && div_tick == '0)); // R1

    AST_GO_RAISES_BUSY: assert property (@(posedge clk) disable iff (rst)
        (go_wr && !busy) |=> busy); // R4

    AST_STATUS_VIEW: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == ADDR_W'(STAT_ADDR)) |-> (bus_rdata == {31'b0, busy})); // R4

    AST_WAIT_FOR_ALIGN: assert property (@(posedge clk) disable iff (rst)
        (busy && !aligned) |=> busy); // R5

    AST_COMMIT_ON_ALIGN: assert property (@(posedge clk) disable iff (rst)
        (busy && aligned) |=> !busy); // R5

    AST_GO_NO_REARM: assert property (@(posedge clk) disable iff (rst)
        (go_wr && busy && aligned) |=> !busy); // R8

    AST_IDLE_STAYS_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!busy && !go_wr) |=> !busy); // R10

endmodule

bind sync_div_bank sync_div_bank_chk #(.NUM_DIV(NUM_DIV), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .div_tick  (div_tick),
    .busy      (busy),
    .aligned   (aligned)
);

// File: tb/sync_div_bank_bench.sv
module sync_div_bank_bench;
    import sdb_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NDIV       = 9;
    localparam int WIN        = 96;
    localparam int NVEC       = 12;

    // Each entry: {divider index[3:0], enable, ratio[4:0]}
    localparam logic [9:0] VEC [NVEC] = '{
        {4'd0, 1'b1, 5'd0},
        {4'd1, 1'b1, 5'd1},
        {4'd2, 1'b1, 5'd2},
        {4'd3, 1'b1, 5'd3},
        {4'd4, 1'b1, 5'd5},
        {4'd5, 1'b1, 5'd7},
        {4'd6, 1'b1, 5'd11},
        {4'd7, 1'b1, 5'd15},
        {4'd8, 1'b1, 5'd31},
        {4'd2, 1'b0, 5'd2},
        {4'd0, 1'b1, 5'd23},
        {4'd2, 1'b1, 5'd1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NDIV-1:0] div_tick;
    logic        busy;

    int checks = 0;
    int failures = 0;

    logic pend_en [NDIV];
    int   pend_r  [NDIV];
    logic act_en  [NDIV];
    int   act_r   [NDIV];
    logic [NDIV-1:0] old_mask;

    always #(CLK_PERIOD/2) clk = ~clk;

    sync_div_bank u_sync_div_bank (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .div_tick  (div_tick),
        .busy      (busy)
    );

    task automatic check(input string req, input logic ok, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        for (int i = 0; i < NDIV; i++) begin
            if (a == div_addr(i)) begin
                pend_en[i] = d[15];
                pend_r[i]  = int'(d[4:0]);
            end
        end
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
        bus_addr = '0;
    endtask

    function automatic logic [31:0] img(input int i);
        logic [31:0] w = '0;
        w[15]  = pend_en[i];
        w[4:0] = 5'(pend_r[i]);
        return w;
    endfunction

    // GO and wait for commit; check the alignment just before busy falls
    task automatic go_and_wait();
        logic [NDIV-1:0] prev;
        int n;
        for (int i = 0; i < NDIV; i++) old_mask[i] = act_en[i];
        wr(12'h138, 32'h1);
        for (int i = 0; i < NDIV; i++) begin
            act_en[i] = pend_en[i];
            act_r[i]  = pend_r[i];
        end
        check("R4 busy after GO", busy == 1'b1, busy, 1);
        prev = div_tick;
        n = 0;
        while (busy && n < 300) begin
            prev = div_tick;
            @(negedge clk);
            n++;
        end
        check("R5 commit reached", busy == 1'b0, busy, 0);
        check("R5 all enabled at terminal count before commit", prev == old_mask, prev, old_mask);
    endtask

    // Window of WIN samples starting at the first idle sample after a commit
    task automatic window(input logic phased);
        int cnt [NDIV];
        int first [NDIV];
        for (int i = 0; i < NDIV; i++) begin cnt[i] = 0; first[i] = -1; end
        for (int k = 0; k < WIN; k++) begin
            for (int i = 0; i < NDIV; i++) begin
                if (div_tick[i]) begin
                    cnt[i]++;
                    if (first[i] < 0) first[i] = k;
                end
            end
            @(negedge clk);
        end
        for (int i = 0; i < NDIV; i++) begin
            if (act_en[i]) begin
                check("R6 strobe count", cnt[i] == WIN / (act_r[i] + 1), cnt[i], WIN / (act_r[i] + 1));
                if (phased)
                    check("R6 first strobe after commit", first[i] == act_r[i], first[i], act_r[i]);
            end else begin
                check("R7 disabled divider silent", cnt[i] == 0, cnt[i], 0);
            end
        end
    endtask

    initial begin
        logic [31:0] d;
        for (int i = 0; i < NDIV; i++) begin
            pend_en[i] = 0; pend_r[i] = 0; act_en[i] = 0; act_r[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 strobes low", div_tick == '0, div_tick, 0);
        check("R1 busy low", busy == 1'b0, busy, 0);
        for (int i = 0; i < NDIV; i++) begin
            rd(div_addr(i), d);
            check("R1 divider reg zero", d == 32'h0, d, 0);
        end
        rd(12'h13C, d);
        check("R1 status zero", d == 32'h0, d, 0);

        // R2 field layout: only ratio and enable retained
        wr(12'h11C, 32'hFFFF_FFFF);
        rd(12'h11C, d);
        check("R2 readback masks", d == 32'h0000_801F, d, 32'h801F);

        // R10 GO with bit 0 clear
        wr(12'h138, 32'h2);
        check("R10 busy stays low", busy == 1'b0, busy, 0);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check("R10 no commit started", busy == 1'b0, busy, 0);
        end

        // Vector table walk
        for (int v = 0; v < NVEC; v++) begin
            int idx;
            logic [31:0] w;
            idx = int'(VEC[v][9:6]);
            w = '0;
            w[15] = VEC[v][5];
            w[4:0] = VEC[v][4:0];
            wr(div_addr(idx), w);
            rd(div_addr(idx), d);
            check("R9 mapped register readback", d == w, d, w);
            go_and_wait();
            window(1'b1);
        end

        // R9 gaps in the map
        wr(12'h124, 32'h0000_801F);
        wr(12'h15C, 32'h0000_801F);
        rd(12'h124, d);
        check("R9 gap reads zero", d == 32'h0, d, 0);
        rd(12'h15C, d);
        check("R9 gap reads zero", d == 32'h0, d, 0);
        for (int i = 0; i < NDIV; i++) begin
            rd(div_addr(i), d);
            check("R9 dividers untouched by gap writes", d == img(i), d, img(i));
        end

        // R3 pending write without GO leaves strobes alone
        wr(div_addr(0), 32'h0000_8005);
        rd(div_addr(0), d);
        check("R3 readback is pending value", d == 32'h0000_8005, d, 32'h8005);
        window(1'b0);
        go_and_wait();
        window(1'b1);

        // R8 GO while busy is ignored
        for (int i = 0; i < NDIV; i++) old_mask[i] = act_en[i];
        wr(12'h138, 32'h1);
        check("R4 busy after GO", busy == 1'b1, busy, 1);
        wr(12'h138, 32'h1);
        check("R8 still busy after repeated GO", busy == 1'b1, busy, 1);
        begin
            int n = 0;
            while (busy && n < 300) begin @(negedge clk); n++; end
        end
        check("R8 single commit", busy == 1'b0, busy, 0);
        for (int k = 0; k < 64; k++) begin
            @(negedge clk);
            check("R8 no re-arm", busy == 1'b0, busy, 0);
        end
        rd(12'h13C, d);
        check("R4 status reflects idle", d == 32'h0, d, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL R5 watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule